// File: doc/BRIEF.md
# Synchronous byte-write burst SRAM

This block is a single-clock static memory whose words are 36 bits wide. Each word is split into four 9-bit byte lanes, and each lane holds 8 data bits with one parity bit in its top position. The address, the address strobe, the chip enable, the advance input, the per-lane write enables, the all-lanes write, the write data and the burst-order select are all captured on the rising clock edge. The output enable is the one exception: it acts on the output at once, with no clock involved.

A cycle with the strobe low and the chip enable low opens an access at the external address. A cycle with the strobe low and the chip enable high deselects the memory. A cycle with the strobe high continues the open access. In such a cycle, a low advance input steps a 2-bit burst counter across the four words of the aligned group. The counter steps either linearly with wrap or in XOR (interleaved) order from the start offset. A high advance input reuses the current address.

Reads are flow-through: the word at the address registered by an edge is visible right after that edge. The read port is plain and has no back-pressure. A valid flag stands in for a driven bus. The flag is high only when an access is open, the last edge performed no write, and the output enable is low. While the flag is low the data output reads zero.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset the memory is deselected: `rvalid_o` is 0 and `rdata_o` is 0 until an access is opened.
- R2: An edge with `strobe_n_i`=0, `ce_n_i`=0 and no write enable low opens a read at `addr_i`. Right after that edge, with `oe_n_i`=0, `rvalid_o` is 1 and `rdata_o` holds the stored word at `addr_i`.
- R3: An edge with `strobe_n_i`=0 and `ce_n_i`=1 deselects the memory. `rvalid_o` drops to 0, and nothing is written even if the write enables are low.
- R4: The write data lane i is bits [9i+8:9i], and bit 9i+8 is that lane's parity bit. When `gw_n_i`=1, a selected edge writes exactly the lanes whose bit `bw_n_i[i]` is 0, and the other lanes keep their old contents.
- R5: When `gw_n_i`=0, a selected edge writes all four lanes, whatever the value of `bw_n_i`.
- R6: A selected edge at which any write enable is low is a write cycle. Right after it `rvalid_o` is 0. A later read of that address returns the newly written bytes.
- R7: `oe_n_i`=1 forces `rvalid_o` to 0 and `rdata_o` to 0 without waiting for a clock edge. Lowering it shows the read word at once.
- R8: An edge with `strobe_n_i`=1 and `adv_n_i`=1 during an open access reuses the current address, for a read or for a write.
- R9: With `order_i`=0 captured at the start, each edge with `strobe_n_i`=1 and `adv_n_i`=0 steps the low two address bits as start+1, start+2, start+3 modulo 4. The upper address bits do not change.
- R10: With `order_i`=1 captured at the start, the k-th advance gives low address bits equal to start XOR k.
- R11: While deselected, edges with `strobe_n_i`=1 leave the memory deselected and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every input except `oe_n_i` is captured on its rising edge |
| rst_n_i | input | 1 | Asynchronous reset, active low; closes any access |
| addr_i | input | AW | Word address used when an access is opened |
| strobe_n_i | input | 1 | Address strobe, active low: opens an access or deselects |
| ce_n_i | input | 1 | Chip enable, active low; only looked at when the strobe is low |
| adv_n_i | input | 1 | Burst advance, active low, during continue cycles |
| order_i | input | 1 | Burst order captured at start: 0 linear, 1 interleaved |
| bw_n_i | input | 4 | Per-lane write enables, active low; bit i is lane i |
| gw_n_i | input | 1 | All-lanes write, active low; overrides `bw_n_i` |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| oe_n_i | input | 1 | Output enable, active low, acts without a clock |
| rdata_o | output | 36 | Read word, or zero when not valid |
| rvalid_o | output | 1 | Read data valid; stands in for a driven bus |

## Verification
The bench builds the memory with AW=6, which gives 64 words. A shadow array that small can be filled completely through the normal write path, so every read compares against a known value. That depth still leaves 16 aligned four-word groups. Bursts therefore run in separate groups with different start offsets, including the wrap from offset 3 back to 0. Any stray change to the upper address bits during a burst, or any write that escapes a deselect, shows up as a mismatch in a word that no test meant to touch.

// File: rtl/sram_pkg.sv
`timescale 1ns/1ps
package sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;
  localparam int OFF_W  = 2;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [OFF_W-1:0]  off_t;
endpackage

// File: rtl/burst_seq.sv
`timescale 1ns/1ps
module burst_seq
  import sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic          strobe_n_i,
  input  logic          ce_n_i,
  input  logic          adv_n_i,
  input  logic          order_i,
  output logic [AW-1:0] eff_addr_o,
  output logic          sel_o,
  output logic [AW-1:0] cur_addr_o,
  output logic          active_o,
  output logic          order_o
);
  localparam int HI_W = AW - OFF_W;

  logic [HI_W-1:0] base_q;
  off_t            start_q, step_q, step_n, off_n, off_q;
  logic            order_q, active_q;
  logic            start_cyc, desel_cyc, cont_cyc, adv_cyc;

  function automatic off_t burst_off(input logic ord, input off_t s, input off_t k);
    return ord ? (s ^ k) : off_t'(s + k);
  endfunction

  always_comb begin
    start_cyc = !strobe_n_i && !ce_n_i;
    desel_cyc = !strobe_n_i && ce_n_i;
    cont_cyc  = strobe_n_i && active_q;
    adv_cyc   = cont_cyc && !adv_n_i;
    step_n    = adv_cyc ? off_t'(step_q + 1'b1) : step_q;
    off_n     = burst_off(order_q, start_q, step_n);
    off_q     = burst_off(order_q, start_q, step_q);
    eff_addr_o = start_cyc ? addr_i : {base_q, off_n};
    sel_o      = start_cyc || cont_cyc;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      base_q   <= '0;
      start_q  <= '0;
      step_q   <= '0;
      order_q  <= 1'b0;
      active_q <= 1'b0;
    end else if (start_cyc) begin
      base_q   <= addr_i[AW-1:OFF_W];
      start_q  <= addr_i[OFF_W-1:0];
      step_q   <= '0;
      order_q  <= order_i;
      active_q <= 1'b1;
    end else if (desel_cyc) begin
      active_q <= 1'b0;
    end else if (adv_cyc) begin
      step_q   <= step_n;
    end
  end

  assign cur_addr_o = {base_q, off_q};
  assign active_o   = active_q;
  assign order_o    = order_q;
endmodule

// File: rtl/lane_ram.sv
`timescale 1ns/1ps
module lane_ram
  import sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  lane_t         wdata_i,
  input  logic [AW-1:0] raddr_i,
  output lane_t         rdata_o
);
  localparam int DEPTH = 1 << AW;

  lane_t store [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) store[waddr_i] <= wdata_i;
  end

  assign rdata_o = store[raddr_i];
endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram
  import sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              strobe_n_i,
  input  logic              ce_n_i,
  input  logic              adv_n_i,
  input  logic              order_i,
  input  logic [LANES-1:0]  bw_n_i,
  input  logic              gw_n_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              oe_n_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [AW-1:0]    eff_addr, cur_addr;
  logic             sel, active, seq_order;
  logic [LANES-1:0] lane_we;
  logic             wr_now, wr_q;
  word_t            rword;

  burst_seq #(.AW(AW)) u_seq (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .addr_i     (addr_i),
    .strobe_n_i (strobe_n_i),
    .ce_n_i     (ce_n_i),
    .adv_n_i    (adv_n_i),
    .order_i    (order_i),
    .eff_addr_o (eff_addr),
    .sel_o      (sel),
    .cur_addr_o (cur_addr),
    .active_o   (active),
    .order_o    (seq_order)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = sel && (!gw_n_i || !bw_n_i[g]);
    lane_ram #(.AW(AW)) u_lane (
      .clk_i   (clk_i),
      .we_i    (lane_we[g]),
      .waddr_i (eff_addr),
      .wdata_i (wdata_i[g*LANE_W +: LANE_W]),
      .raddr_i (cur_addr),
      .rdata_o (rword[g*LANE_W +: LANE_W])
    );
  end

  assign wr_now = |lane_we;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) wr_q <= 1'b0;
    else          wr_q <= wr_now;
  end

  assign rvalid_o = active && !wr_q && !oe_n_i;
  assign rdata_o  = rvalid_o ? rword : '0;
endmodule

// File: rtl/burst_sram_chk.sv
`timescale 1ns/1ps
module burst_sram_chk #(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_n_i,
  input logic [AW-1:0] addr_i,
  input logic          strobe_n_i,
  input logic          ce_n_i,
  input logic          adv_n_i,
  input logic          oe_n_i,
  input logic          rvalid_o,
  input logic [35:0]   rdata_o,
  input logic [AW-1:0] cur_addr,
  input logic          active,
  input logic          seq_order,
  input logic          sel,
  input logic [3:0]    bw_n_i,
  input logic          gw_n_i
);
  assert_deselect_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!strobe_n_i && ce_n_i) |=> !rvalid_o);

  assert_start_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!strobe_n_i && !ce_n_i) |=> (cur_addr == $past(addr_i)));

  assert_write_hides_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (sel && (!gw_n_i || (bw_n_i != 4'hF))) |=> !rvalid_o);

  assert_oe_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    oe_n_i |-> (!rvalid_o && rdata_o == '0));

  assert_hold_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (strobe_n_i && adv_n_i) |=> $stable(cur_addr));

  assert_linear_step_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (strobe_n_i && active && !adv_n_i && !seq_order) |=>
      (cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1)) &&
      (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

  assert_idle_stays_R11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (strobe_n_i && !active) |=> !active);
endmodule

bind sync_burst_sram burst_sram_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_n_i    (rst_n_i),
  .addr_i     (addr_i),
  .strobe_n_i (strobe_n_i),
  .ce_n_i     (ce_n_i),
  .adv_n_i    (adv_n_i),
  .oe_n_i     (oe_n_i),
  .rvalid_o   (rvalid_o),
  .rdata_o    (rdata_o),
  .cur_addr   (cur_addr),
  .active     (active),
  .seq_order  (seq_order),
  .sel        (sel),
  .bw_n_i     (bw_n_i),
  .gw_n_i     (gw_n_i)
);

// File: tb/test_sync_burst_sram.sv
`timescale 1ns/1ps
module test_sync_burst_sram;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          strobe_n = 1'b1, ce_n = 1'b1, adv_n = 1'b1, order = 1'b0;
  logic [3:0]    bw_n = 4'hF;
  logic          gw_n = 1'b1;
  logic [35:0]   wdata = '0;
  logic          oe_n = 1'b0;
  logic [35:0]   rdata;
  logic          rvalid;

  logic [35:0] shadow [DEPTH];
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sync_burst_sram #(.AW(AW)) i_sync_burst_sram (
    .clk_i(clk), .rst_n_i(rst_n), .addr_i(addr), .strobe_n_i(strobe_n),
    .ce_n_i(ce_n), .adv_n_i(adv_n), .order_i(order), .bw_n_i(bw_n),
    .gw_n_i(gw_n), .wdata_i(wdata), .oe_n_i(oe_n),
    .rdata_o(rdata), .rvalid_o(rvalid)
  );

  function automatic logic [35:0] pat(input int a, input int salt);
    return 36'((a * 36'h9E3779B9) ^ (salt * 36'h5A5A5A5A5) ^ 36'hA_1234_5678);
  endfunction

  task automatic chk(input string req, input logic ev, input logic [35:0] ed);
    n_vec++;
    if (rvalid !== ev || rdata !== (ev ? ed : 36'h0)) begin
      n_bad++;
      $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               req, rvalid, rdata, ev, ev ? ed : 36'h0);
    end
  endtask

  // Drive one cycle's inputs, pass the rising edge, settle away from it.
  task automatic cyc(input logic sn, input logic cn, input logic an,
                     input logic gn, input logic [3:0] bn,
                     input logic [AW-1:0] a, input logic [35:0] d);
    strobe_n = sn; ce_n = cn; adv_n = an; gw_n = gn; bw_n = bn;
    addr = a; wdata = d;
    @(posedge clk);
    #1.5;
  endtask

  task automatic idle();
    cyc(1, 1, 1, 1, 4'hF, '0, '0);
  endtask

  task automatic t_reset();
    chk("R1", 0, '0);
    idle();
    chk("R1", 0, '0);
  endtask

  task automatic t_fill();
    for (int a = 0; a < DEPTH; a++) begin
      cyc(0, 0, 1, 0, 4'hF, AW'(a), pat(a, 0));
      shadow[a] = pat(a, 0);
      if (a == 5) chk("R6", 0, '0);
    end
    cyc(0, 0, 1, 1, 4'hF, AW'(5), '0);
    chk("R2", 1, shadow[5]);
    cyc(0, 0, 1, 1, 4'hF, AW'(63), '0);
    chk("R5", 1, shadow[63]);
  endtask

  task automatic t_byte_write();
    logic [35:0] nd = pat(11, 7);
    cyc(0, 0, 1, 1, 4'b1010, AW'(11), nd);
    chk("R6", 0, '0);
    shadow[11][8:0]   = nd[8:0];
    shadow[11][26:18] = nd[26:18];
    cyc(0, 0, 1, 1, 4'hF, AW'(11), '0);
    chk("R4", 1, shadow[11]);
    nd = pat(11, 9);
    cyc(0, 0, 1, 1, 4'b0111, AW'(11), nd);
    shadow[11][35:27] = nd[35:27];
    cyc(0, 0, 1, 1, 4'hF, AW'(11), '0);
    chk("R4", 1, shadow[11]);
  endtask

  task automatic t_global();
    logic [35:0] nd = pat(20, 3);
    cyc(0, 0, 1, 0, 4'hF, AW'(20), nd);
    shadow[20] = nd;
    cyc(0, 0, 1, 1, 4'hF, AW'(20), '0);
    chk("R5", 1, shadow[20]);
    nd = pat(20, 4);
    cyc(0, 0, 1, 0, 4'b1110, AW'(20), nd);
    shadow[20] = nd;
    cyc(0, 0, 1, 1, 4'hF, AW'(20), '0);
    chk("R5", 1, shadow[20]);
  endtask

  task automatic t_deselect();
    cyc(0, 0, 1, 1, 4'hF, AW'(30), '0);
    chk("R2", 1, shadow[30]);
    cyc(0, 1, 1, 0, 4'h0, AW'(30), 36'hF_FFFF_FFFF);
    chk("R3", 0, '0);
    cyc(1, 0, 1, 0, 4'h0, AW'(30), 36'hF_FFFF_FFFF);
    chk("R11", 0, '0);
    cyc(1, 0, 0, 0, 4'h0, AW'(31), 36'hF_FFFF_FFFF);
    chk("R11", 0, '0);
    cyc(0, 0, 1, 1, 4'hF, AW'(30), '0);
    chk("R3", 1, shadow[30]);
    cyc(0, 0, 1, 1, 4'hF, AW'(28), '0);
    chk("R11", 1, shadow[28]);
    cyc(0, 0, 1, 1, 4'hF, AW'(31), '0);
    chk("R11", 1, shadow[31]);
  endtask

  task automatic t_oe();
    oe_n = 1'b1;
    cyc(0, 0, 1, 1, 4'hF, AW'(40), '0);
    chk("R7", 0, '0);
    oe_n = 1'b0;
    #0.5;
    chk("R7", 1, shadow[40]);
    oe_n = 1'b1;
    #0.5;
    chk("R7", 0, '0);
    oe_n = 1'b0;
    #0.1;
  endtask

  task automatic t_hold();
    logic [35:0] nd = pat(44, 5);
    cyc(0, 0, 1, 1, 4'hF, AW'(44), '0);
    cyc(1, 0, 1, 1, 4'hF, AW'(9), '0);
    chk("R8", 1, shadow[44]);
    cyc(1, 0, 1, 0, 4'hF, AW'(9), nd);
    shadow[44] = nd;
    chk("R8", 0, '0);
    cyc(1, 0, 1, 1, 4'hF, AW'(9), '0);
    chk("R8", 1, shadow[44]);
    cyc(0, 0, 1, 1, 4'hF, AW'(9), '0);
    chk("R8", 1, shadow[9]);
  endtask

  task automatic t_burst(input logic ord, input int base, input int s, input string req);
    order = ord;
    cyc(0, 0, 1, 1, 4'hF, AW'(base + s), '0);
    order = ~ord;
    chk(req, 1, shadow[base + s]);
    for (int k = 1; k < 4; k++) begin
      int off = ord ? (s ^ k) : ((s + k) % 4);
      cyc(1, 0, 0, 1, 4'hF, AW'(0), '0);
      chk(req, 1, shadow[base + off]);
    end
    order = 1'b0;
  endtask

  task automatic t_burst_write();
    int offs [4] = '{1, 0, 3, 2};
    order = 1'b1;
    cyc(0, 0, 1, 0, 4'hF, AW'(49), pat(49, 8));
    shadow[49] = pat(49, 8);
    for (int k = 1; k < 4; k++) begin
      cyc(1, 0, 0, 0, 4'hF, AW'(0), pat(48 + offs[k], 8));
      shadow[48 + offs[k]] = pat(48 + offs[k], 8);
    end
    order = 1'b0;
    for (int w = 48; w < 52; w++) begin
      cyc(0, 0, 1, 1, 4'hF, AW'(w), '0);
      chk("R10", 1, shadow[w]);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    rst_n = 1'b1;
    idle();
    t_reset();
    t_fill();
    t_byte_write();
    t_global();
    t_deselect();
    t_oe();
    t_hold();
    t_burst(1'b0, 12, 0, "R9");
    t_burst(1'b0, 32, 3, "R9");
    t_burst(1'b1, 36, 2, "R10");
    t_burst(1'b1, 56, 1, "R10");
    t_burst_write();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule